// File: doc/BRIEF.md
# Flash Status Word Generator

While the flash erase/program engine is working, or while an erase is suspended, reads aimed at the array must return a status word instead of stored data. This block builds that word from the engine's operation state, bit 7 of the word being programmed, the address of each read, the block being erased and the engine's failure reports. It also drives a select line that tells the read mux whether to return the status word or the array data.

Five bits of the word carry status. Bit 7 is the polling flag. Bits 6 and 2 are two toggle flags that flip on read accesses, not on clock cycles. Bit 5 is a sticky failure flag. Bit 3 marks the window in which the engine is still accepting block-erase addresses. All other bits read as zero. The block also gives a fixed-length hold after an erase aimed at a protected block, so that polling software sees a short busy period before array data returns. The block decodes a read address with `(rd_addr >> BLK_LSB)`, and the result is compared with the erase block number.

Top module: `fsw_status_gen`

## Requirements
- R1: Only bits 7, 6, 5, 3 and 2 of `stat_word` may be 1. When `stat_sel` is 0, `stat_word` is all zero. After reset, with mode idle and no pending events, `stat_sel` is 0 and both toggle flags are 0.
- R2: In program mode (`op_mode`=1), `stat_sel` is 1 and bit 7 equals the inverse of `prog_b7`.
- R3: In erase mode (`op_mode`=2) and in the erase acceptance window (`op_mode`=3), `stat_sel` is 1 and bit 7 is 0. Bit 3 is 1 only in the window, and 0 in every other mode.
- R4: In program, erase and window modes, bit 6 shows the toggle flag A. A cycle with `rd_strobe`=1 inverts flag A after it has been read. A cycle without a strobe leaves it unchanged, so back-to-back reads alternate.
- R5: Bit 2 shows toggle flag B and inverts after each read in these cases: in erase mode; in suspend mode (`op_mode`=4) for reads inside block `erase_blk`; and in idle mode with an error pending, for reads inside the failed block. In other cases bit 2 is 0 and flag B keeps its value.
- R6: In suspend mode, a read inside block `erase_blk` gives `stat_sel`=1, bit 7=1 and bit 6=1. With no error pending, a read of any other block gives `stat_sel`=0.
- R7: An `op_fail` pulse sets the error flag (bit 5) and records `erase_blk` as the failed block. The flag stays set until a `rst_cmd` pulse clears it. If both pulses occur in the same cycle, the flag ends up set. While the flag is set, `stat_sel` is 1.
- R8: After a `prot_hit` pulse, for exactly HOLD_CYC cycles, `stat_sel` is 1 and, in idle mode, bit 7 is 0.
- R9: Mode codes 5 to 7 behave exactly like idle (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 3 | 0 idle, 1 program, 2 erase, 3 erase acceptance window, 4 erase suspended |
| prog_b7 | input | 1 | Bit 7 of the word being programmed |
| rd_strobe | input | 1 | One pulse per read access of the array |
| rd_addr | input | AW | Address of the current read |
| erase_blk | input | BW | Block being erased or erase-suspended |
| op_fail | input | 1 | Pulse: program or erase failed (includes writing 1 over 0) |
| rst_cmd | input | 1 | Pulse: read/reset command accepted |
| prot_hit | input | 1 | Pulse: erase aimed at a protected block |
| stat_word | output | 16 | Status word returned for reads |
| stat_sel | output | 1 | 1 selects the status word, 0 selects array data |

## Verification
The assertions assume that `op_fail`, `rst_cmd` and `prot_hit` are single-cycle pulses. They also assume that `op_mode` and `erase_blk` hold steady around each read strobe, because the toggle checks compare the flags across one edge. The bench drives every input on the falling edge, raises each pulse for exactly one cycle, and changes mode only between reads. It runs a small configuration: four blocks of 64 addresses each and a five-cycle hold. This makes it possible to sweep every pairing of read block and erase block in every mode, with the toggle flags tracked by a separate model in the bench.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic [2:0] {
    FSW_IDLE  = 3'd0,
    FSW_PROG  = 3'd1,
    FSW_ERASE = 3'd2,
    FSW_EWIN  = 3'd3,
    FSW_SUSP  = 3'd4
  } fsw_mode_e;

  localparam int FSW_W  = 16;
  localparam int B_POLL = 7;
  localparam int B_TGA  = 6;
  localparam int B_ERR  = 5;
  localparam int B_WIN  = 3;
  localparam int B_TGB  = 2;

  // Codes outside the defined set fold to idle.
  function automatic fsw_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    decode_mode = FSW_PROG;
      3'd2:    decode_mode = FSW_ERASE;
      3'd3:    decode_mode = FSW_EWIN;
      3'd4:    decode_mode = FSW_SUSP;
      default: decode_mode = FSW_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/fsw_toggle.sv
module fsw_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (flip_i) q_o <= ~q_o;
  end

  // R4 / R5: one inversion per qualified read, none otherwise
  a_r4_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    flip_i |=> (q_o != $past(q_o)));
  a_r5_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_i |=> $stable(q_o));
endmodule

// File: rtl/fsw_err_track.sv
module fsw_err_track #(
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fail_i,
  input  logic          clr_i,
  input  logic [BW-1:0] blk_i,
  output logic          err_o,
  output logic [BW-1:0] fblk_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o  <= 1'b0;
      fblk_o <= '0;
    end else begin
      err_o <= fail_i | (err_o & ~clr_i);
      if (fail_i) fblk_o <= blk_i;
    end
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fail_i) |=> !err_o);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |=> (err_o && fblk_o == $past(blk_i)));
endmodule

// File: rtl/fsw_hold_timer.sv
module fsw_hold_timer #(
  parameter int HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic hold_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (hit_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);

  a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> hold_o);
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && hold_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fsw_status_gen.sv
module fsw_status_gen
  import fsw_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BW       = 3,
  parameter int BLK_LSB  = 13,
  parameter int HOLD_CYC = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_mode,
  input  logic          prog_b7,
  input  logic          rd_strobe,
  input  logic [AW-1:0] rd_addr,
  input  logic [BW-1:0] erase_blk,
  input  logic          op_fail,
  input  logic          rst_cmd,
  input  logic          prot_hit,
  output logic [15:0]   stat_word,
  output logic          stat_sel
);
  function automatic logic blk_match(input logic [AW-1:0] a, input logic [BW-1:0] b);
    logic [AW-1:0] wide_b;
    wide_b = AW'(b);
    return ((a >> BLK_LSB) == wide_b);
  endfunction

  fsw_mode_e mode;
  logic busy, in_susp, in_fail;
  logic err, hold;
  logic [BW-1:0] fblk;
  logic tga_q, tgb_q;
  logic tga_live, tgb_live;
  logic flip_a, flip_b;

  assign mode    = decode_mode(op_mode);
  assign busy    = (mode == FSW_PROG) || (mode == FSW_ERASE) || (mode == FSW_EWIN);
  assign in_susp = blk_match(rd_addr, erase_blk);
  assign in_fail = blk_match(rd_addr, fblk);

  // Conditions under which each toggle flag is visible (and may flip on a read)
  assign tga_live = busy;
  assign tgb_live = (mode == FSW_ERASE)
                 || ((mode == FSW_SUSP) && in_susp)
                 || ((mode == FSW_IDLE) && err && in_fail);

  assign flip_a = rd_strobe & tga_live;
  assign flip_b = rd_strobe & tgb_live;

  fsw_toggle u_tga (.clk(clk), .rst_n(rst_n), .flip_i(flip_a), .q_o(tga_q));
  fsw_toggle u_tgb (.clk(clk), .rst_n(rst_n), .flip_i(flip_b), .q_o(tgb_q));

  fsw_err_track #(.BW(BW)) u_err (
    .clk(clk), .rst_n(rst_n), .fail_i(op_fail), .clr_i(rst_cmd),
    .blk_i(erase_blk), .err_o(err), .fblk_o(fblk)
  );

  fsw_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .hit_i(prot_hit), .hold_o(hold)
  );

  logic poll_bit;
  always_comb begin
    case (mode)
      FSW_PROG: poll_bit = ~prog_b7;
      FSW_SUSP: poll_bit = 1'b1;
      default:  poll_bit = 1'b0;
    endcase
  end

  assign stat_sel = busy | hold | err | ((mode == FSW_SUSP) & in_susp);

  always_comb begin
    stat_word = '0;
    if (stat_sel) begin
      stat_word[B_POLL] = poll_bit;
      stat_word[B_TGA]  = tga_live ? tga_q : ((mode == FSW_SUSP) && in_susp);
      stat_word[B_ERR]  = err;
      stat_word[B_WIN]  = (mode == FSW_EWIN);
      stat_word[B_TGB]  = tgb_live & tgb_q;
    end
  end

  // R1: reserved bits never set
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & 16'h0013) == 16'h0000 && (stat_word & 16'hFF00) == 16'h0000);
  // R2
  a_r2_poll_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'd1) |-> (stat_sel && stat_word[7] == ~prog_b7));
  // R3
  a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'd2 || op_mode == 3'd3) |-> (stat_sel && !stat_word[7]));
  // R6
  a_r6_susp_block: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 3'd4 && in_susp) |-> (stat_sel && stat_word[7] && stat_word[6]));
  // R1 / R9: quiet idle returns array data
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode != FSW_SUSP && !err && !hold) |-> (!stat_sel && stat_word == 16'h0));
endmodule

// File: tb/sim_fsw_status_gen.sv
module sim_fsw_status_gen;
  localparam int AW = 8, BW = 2, BLK_LSB = 6, HOLD = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_mode = 3'd0;
  logic          prog_b7 = 1'b0;
  logic          rd_strobe = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [BW-1:0] erase_blk = '0;
  logic          op_fail = 1'b0, rst_cmd = 1'b0, prot_hit = 1'b0;
  logic [15:0]   stat_word;
  logic          stat_sel;

  always #5 clk = ~clk;

  fsw_status_gen #(.AW(AW), .BW(BW), .BLK_LSB(BLK_LSB), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .prog_b7(prog_b7),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .erase_blk(erase_blk),
    .op_fail(op_fail), .rst_cmd(rst_cmd), .prot_hit(prot_hit),
    .stat_word(stat_word), .stat_sel(stat_sel)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // bench model
  bit m_a = 0, m_b = 0, m_err = 0;
  int m_fblk = 0, m_hold = 0;

  function automatic int mcode(input logic [2:0] c);
    return (c > 3'd4) ? 0 : int'(c);
  endfunction
  function automatic int blk(input logic [AW-1:0] a);
    return int'(a) / (1 << BLK_LSB);
  endfunction

  function automatic bit live_b();
    int m = mcode(op_mode);
    return (m == 2) || (m == 4 && blk(rd_addr) == int'(erase_blk)) ||
           (m == 0 && m_err && blk(rd_addr) == m_fblk);
  endfunction

  task automatic check(input string req);
    int m = mcode(op_mode);
    bit ins = (blk(rd_addr) == int'(erase_blk));
    bit busy = (m >= 1 && m <= 3);
    bit esel = busy || m_hold > 0 || m_err || (m == 4 && ins);
    logic [15:0] ew = 16'h0;
    if (esel) begin
      ew[7] = (m == 1) ? !prog_b7 : (m == 4);
      ew[6] = busy ? m_a : (m == 4 && ins);
      ew[5] = m_err;
      ew[3] = (m == 3);
      ew[2] = live_b() ? m_b : 1'b0;
    end
    n_cmp++;
    if (stat_word !== ew || stat_sel !== esel) begin
      n_bad++;
      $display("FAIL %s: word=%h sel=%b expected word=%h sel=%b", req, stat_word, stat_sel, ew, esel);
    end
  endtask

  // advance one clock, updating the bench model from the inputs held across the edge
  task automatic step();
    int m = mcode(op_mode);
    bit fa = rd_strobe && (m >= 1 && m <= 3);
    bit fb = rd_strobe && live_b();
    @(posedge clk);
    if (fa) m_a = !m_a;
    if (fb) m_b = !m_b;
    if (op_fail) m_fblk = int'(erase_blk);
    m_err = op_fail || (m_err && !rst_cmd);
    if (prot_hit) m_hold = HOLD; else if (m_hold > 0) m_hold--;
    @(negedge clk);
    rd_strobe = 0; op_fail = 0; rst_cmd = 0; prot_hit = 0;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    rd_addr = a; rd_strobe = 1; #1;
    check(req);
    step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1; #1;
    check("R1 reset state");
    step(); check("R1 idle after reset");

    // R2: program mode, both bit-7 values, back-to-back reads (R4 alternation)
    for (int p = 0; p < 2; p++) begin
      op_mode = 3'd1; prog_b7 = p[0];
      for (int k = 0; k < 4; k++) rd(8'(k * 37), "R2 R4 program poll/toggle");
      step(); check("R4 no flip without read");
    end

    // R3 / R5: erase and window modes across all addresses blocks
    for (int md = 2; md <= 3; md++) begin
      op_mode = 3'(md);
      for (int a = 0; a < 256; a += 13) rd(8'(a), "R3 R4 R5 erase/window");
    end

    // R6 / R5: suspend, sweep erase block x read block
    op_mode = 3'd4;
    for (int e = 0; e < 4; e++) begin
      erase_blk = 2'(e);
      for (int b = 0; b < 4; b++) begin
        rd(8'(b * 64 + 5), "R6 R5 suspend read");
        rd(8'(b * 64 + 63), "R6 R5 suspend read again");
      end
    end

    // R7: failure during erase, faulty block toggles in idle
    op_mode = 3'd2; erase_blk = 2'd2; op_fail = 1; #1; step();
    op_mode = 3'd0; #1; check("R7 error sets sel");
    for (int b = 0; b < 4; b++) begin
      rd(8'(b * 64 + 9), "R7 R5 faulty block toggle");
      rd(8'(b * 64 + 9), "R7 R5 faulty block toggle 2");
    end
    rst_cmd = 1; #1; step(); check("R7 cleared by read/reset");
    op_fail = 1; rst_cmd = 1; erase_blk = 2'd1; #1; step(); check("R7 set wins");
    rd(8'd70, "R7 R5 new faulty block");
    rst_cmd = 1; #1; step(); check("R7 cleared again");

    // R8: protected-block hold timer
    prot_hit = 1; #1; step();
    for (int c = 0; c < HOLD + 3; c++) begin
      check("R8 hold window");
      step();
    end
    prot_hit = 1; #1; step();
    op_mode = 3'd1; prog_b7 = 1; #1; check("R8 R2 hold in program");
    repeat (HOLD) step();
    op_mode = 3'd0; #1; check("R8 hold expired");

    // R9: unused codes act as idle, also with error pending
    for (int c = 5; c < 8; c++) begin
      op_mode = 3'(c);
      rd(8'd10, "R9 unused code quiet");
    end
    op_fail = 1; erase_blk = 2'd0; #1; step();
    for (int c = 5; c < 8; c++) begin
      op_mode = 3'(c);
      rd(8'd3, "R9 R5 unused code with error");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule